// File: doc/BRIEF.md
# Fused LSTM Gate Pre-Activation Unit

This block produces the pre-activation sums of three LSTM gates (labelled a, i and o) in a single matrix-vector pass. The current input vector x(t), which holds m words, is placed in front of the previous hidden output h(t-1), which holds n words. The result is one operand of m+n columns. That operand is multiplied by one stacked weight matrix of 3n rows, in which the three gate matrices lie one above the other. The output for each row is a single fixed-point word. The unit steers each word to the output stream of its own gate, so that the a, i and o vectors can go straight to separate activation stages.

A pass starts with a one-cycle start pulse, which captures m and n. The unit then takes the m input words on the x stream. Next it takes the weights on the w stream, one word per accepted beat, in row-major order. The h(t-1) words come from a small local RAM. Whatever produces the hidden state writes that RAM between passes. Every word is signed Q4.12. Products sum in a 40-bit accumulator, and each sum is rounded and saturated back to Q4.12 on the way out. A downstream consumer that is not ready stalls the unit, and no word is lost.

Top module: `lstm_gate_mvu`

## Requirements
- R1: After a synchronous active-low reset, busy, done, x_ready and w_ready are low and no gate_valid bit is set.
- R2: A start pulse while idle latches cfg_m and cfg_n and sets busy. The unit then raises x_ready and takes exactly cfg_m words on the x stream. x_ready and w_ready are never high in the same cycle.
- R3: Column c of the operand is x word c when c < m, and hidden RAM entry c-m otherwise. Weights are taken in row-major order, m+n words per row, with row 0 first.
- R4: Results leave in row order. Row r goes out on gate index r/n: 0 carries a (bits [15:0] of gate_data), 1 carries i (bits [31:16]) and 2 carries o (bits [47:32]). The matching gate_tag field holds r mod n.
- R5: Each result is the sum of the row's Q4.12 products. It is rounded half up (add 2^11, then take the floor after an arithmetic shift right by 12).
- R6: A rounded sum above 32767 leaves as 0x7FFF. A rounded sum below -32768 leaves as 0x8000.
- R7: While a result is offered and not accepted, its valid bit and its data hold steady and w_ready stays low.
- R8: At most one gate_valid bit is high in any cycle.
- R9: done is high for exactly one cycle, the cycle after the last result of a pass is accepted. busy is low in that cycle.
- R10: A start pulse while busy is ignored. The running pass ends with the dimensions it latched.
- R11: A hidden RAM write (h_wr_en, h_wr_addr, h_wr_data) made while idle is used as h(t-1) by the next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a pass when idle |
| cfg_m | input | 4 | Input vector length m (1..MAX_M) |
| cfg_n | input | 4 | Cell count n (1..MAX_N) |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| x_valid | input | 1 | Input word offered |
| x_ready | output | 1 | Input word taken |
| x_data | input | 16 | Input word, Q4.12 |
| w_valid | input | 1 | Weight word offered |
| w_ready | output | 1 | Weight word taken |
| w_data | input | 16 | Weight word, Q4.12 |
| h_wr_en | input | 1 | Hidden RAM write enable |
| h_wr_addr | input | 3 | Hidden RAM write address |
| h_wr_data | input | 16 | Hidden RAM write data, Q4.12 |
| gate_valid | output | 3 | Result offered on gate stream a/i/o |
| gate_ready | input | 3 | Result taken per gate stream |
| gate_data | output | 48 | Per-gate result words, Q4.12 |
| gate_tag | output | 9 | Per-gate cell index of the result |

## Verification
The bound assertions check the handshake rules on every cycle. These rules are that at most one gate stream is valid, that an unaccepted result holds steady, that no weight is taken while a result is pending, that the x and w streams are exclusive, and that done is a single pulse following the final acceptance. Several behaviours can only be shown by the bench comparing output against a reference model over whole passes. These are the numerical results, the concatenation order of x and h, the row-to-gate routing and tags, rounding and saturation at the limits, the hidden RAM update, and the start pulse being ignored while busy.

// File: rtl/lstm_mvu_pkg.sv
// Shared definitions for the fused LSTM gate unit.
// Assumes: nothing beyond IEEE 1800-2017.
package lstm_mvu_pkg;

    localparam int GATES = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOADX,
        ST_MAC,
        ST_EMIT,
        ST_FIN
    } mvu_state_t;

endpackage

// File: rtl/lstm_mvu_opnd.sv
// Operand store: the x(t) buffer and the h(t-1) RAM, read as one concatenated
// vector in which columns below m come from x and the rest from hidden RAM.
// Assumes: rd_col < m + n; storage needs no reset because every x word is written
// before use and hidden entries are written by the caller before a pass.
module lstm_mvu_opnd #(
    parameter int DW    = 16,
    parameter int MAX_M = 8,
    parameter int MAX_N = 8,
    localparam int XAW  = $clog2(MAX_M),
    localparam int HAW  = $clog2(MAX_N),
    localparam int MW   = $clog2(MAX_M + 1),
    localparam int CW   = $clog2(MAX_M + MAX_N + 1)
) (
    input  logic                 clk,
    input  logic                 x_we,
    input  logic [XAW-1:0]       x_addr,
    input  logic signed [DW-1:0] x_wdata,
    input  logic                 h_we,
    input  logic [HAW-1:0]       h_addr,
    input  logic signed [DW-1:0] h_wdata,
    input  logic [MW-1:0]        m_len,
    input  logic [CW-1:0]        rd_col,
    output logic signed [DW-1:0] operand
);

    logic signed [DW-1:0] xbuf [MAX_M];
    logic signed [DW-1:0] hram [MAX_N];
    logic [CW-1:0]        hidx;

    // Capture input words as they are accepted.
    always_ff @(posedge clk) begin
        if (x_we) xbuf[x_addr] <= x_wdata;
    end

    // Hidden state writes from the producer of h(t-1).
    always_ff @(posedge clk) begin
        if (h_we) hram[h_addr] <= h_wdata;
    end

    // Select x or h by column position.
    always_comb begin
        hidx = rd_col - CW'(m_len);
        if (rd_col < CW'(m_len)) operand = xbuf[rd_col[XAW-1:0]];
        else                     operand = hram[hidx[HAW-1:0]];
    end

endmodule

// File: rtl/lstm_mvu_mac.sv
// Multiply-accumulate lane: sums one row of products and, on the row's last beat,
// rounds half up and saturates the total back to the operand format.
// Assumes: ACCW >= 2*DW and a row is short enough not to wrap the accumulator.
module lstm_mvu_mac #(
    parameter int DW   = 16,
    parameter int FRAC = 12,
    parameter int ACCW = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 beat,
    input  logic                 last,
    input  logic signed [DW-1:0] w,
    input  logic signed [DW-1:0] op,
    output logic signed [DW-1:0] result
);

    localparam logic signed [ACCW-1:0] HALF = ACCW'(1) << (FRAC - 1);
    localparam logic signed [ACCW-1:0] HI   = ACCW'((64'sd1 <<< (DW - 1)) - 1);
    localparam logic signed [ACCW-1:0] LO   = ~HI;

    logic signed [2*DW-1:0] prod;
    logic signed [ACCW-1:0] acc, sum, rnd;
    logic signed [DW-1:0]   sat;

    // Product, running sum and the rounded, clamped row result.
    always_comb begin
        prod = w * op;
        sum  = acc + {{(ACCW - 2*DW){prod[2*DW-1]}}, prod};
        rnd  = (sum + HALF) >>> FRAC;
        if (rnd > HI)      sat = HI[DW-1:0];
        else if (rnd < LO) sat = LO[DW-1:0];
        else               sat = rnd[DW-1:0];
    end

    // Accumulate per beat; close the row on its last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            result <= '0;
        end else if (beat) begin
            if (last) begin
                acc    <= '0;
                result <= sat;
            end else begin
                acc <= sum;
            end
        end
    end

endmodule

// File: rtl/lstm_mvu_demux.sv
// Gate demultiplexer: offers the single row result on the stream of its gate and
// reports when that stream accepts it.
// Assumes: gate < GATES while valid is high.
module lstm_mvu_demux
    import lstm_mvu_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 3
) (
    input  logic                valid,
    input  logic [1:0]          gate,
    input  logic [DW-1:0]       data,
    input  logic [TW-1:0]       tag,
    input  logic [GATES-1:0]    out_ready,
    output logic [GATES-1:0]    out_valid,
    output logic [GATES*DW-1:0] out_data,
    output logic [GATES*TW-1:0] out_tag,
    output logic                taken
);

    // One stream slice per gate.
    for (genvar g = 0; g < GATES; g++) begin : g_slice
        assign out_valid[g]            = valid && (gate == 2'(g));
        assign out_data[g*DW +: DW]    = data;
        assign out_tag[g*TW +: TW]     = tag;
    end

    assign taken = |(out_valid & out_ready);

endmodule

// File: rtl/lstm_gate_mvu.sv
// Fused three-gate matrix-vector unit: loads x(t), streams a stacked 3n x (m+n)
// weight matrix row by row against [x(t), h(t-1)], and emits one rounded Q4.12
// word per row on the stream of the gate that row belongs to.
// Assumes: 1 <= cfg_m <= MAX_M, 1 <= cfg_n <= MAX_N; hidden RAM written while idle.
module lstm_gate_mvu
    import lstm_mvu_pkg::*;
#(
    parameter int DW    = 16,
    parameter int FRAC  = 12,
    parameter int ACCW  = 40,
    parameter int MAX_M = 8,
    parameter int MAX_N = 8,
    localparam int MW   = $clog2(MAX_M + 1),
    localparam int NW   = $clog2(MAX_N + 1),
    localparam int XAW  = $clog2(MAX_M),
    localparam int HAW  = $clog2(MAX_N),
    localparam int CW   = $clog2(MAX_M + MAX_N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [MW-1:0]        cfg_m,
    input  logic [NW-1:0]        cfg_n,
    output logic                 busy,
    output logic                 done,
    input  logic                 x_valid,
    output logic                 x_ready,
    input  logic [DW-1:0]        x_data,
    input  logic                 w_valid,
    output logic                 w_ready,
    input  logic [DW-1:0]        w_data,
    input  logic                 h_wr_en,
    input  logic [HAW-1:0]       h_wr_addr,
    input  logic [DW-1:0]        h_wr_data,
    output logic [GATES-1:0]     gate_valid,
    input  logic [GATES-1:0]     gate_ready,
    output logic [GATES*DW-1:0]  gate_data,
    output logic [GATES*HAW-1:0] gate_tag
);

    mvu_state_t           state;
    logic [MW-1:0]        m_r;
    logic [NW-1:0]        n_r;
    logic [CW-1:0]        col;
    logic [1:0]           gate;
    logic [HAW-1:0]       lane;
    logic                 x_fire, w_fire, out_fire;
    logic                 x_last, col_last, lane_last;
    logic signed [DW-1:0] operand, result;

    // Handshake and end-of-count decodes.
    always_comb begin
        x_ready   = (state == ST_LOADX);
        w_ready   = (state == ST_MAC);
        busy      = (state != ST_IDLE) && (state != ST_FIN);
        done      = (state == ST_FIN);
        x_fire    = x_valid && x_ready;
        w_fire    = w_valid && w_ready;
        x_last    = (col == CW'(m_r) - CW'(1));
        col_last  = (col == CW'(m_r) + CW'(n_r) - CW'(1));
        lane_last = (lane == HAW'(n_r - NW'(1)));
    end

    // Pass sequencer: load x, run each row, hand off each result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            m_r   <= '0;
            n_r   <= '0;
            col   <= '0;
            gate  <= '0;
            lane  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    m_r   <= cfg_m;
                    n_r   <= cfg_n;
                    col   <= '0;
                    gate  <= '0;
                    lane  <= '0;
                    state <= ST_LOADX;
                end
                ST_LOADX: if (x_fire) begin
                    col <= x_last ? '0 : col + CW'(1);
                    if (x_last) state <= ST_MAC;
                end
                ST_MAC: if (w_fire) begin
                    col <= col_last ? '0 : col + CW'(1);
                    if (col_last) state <= ST_EMIT;
                end
                ST_EMIT: if (out_fire) begin
                    if (!lane_last) begin
                        lane  <= lane + HAW'(1);
                        state <= ST_MAC;
                    end else begin
                        lane <= '0;
                        if (gate == 2'(GATES - 1)) begin
                            state <= ST_FIN;
                        end else begin
                            gate  <= gate + 2'd1;
                            state <= ST_MAC;
                        end
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    lstm_mvu_opnd #(.DW(DW), .MAX_M(MAX_M), .MAX_N(MAX_N)) u_opnd (
        .clk     (clk),
        .x_we    (x_fire),
        .x_addr  (col[XAW-1:0]),
        .x_wdata (x_data),
        .h_we    (h_wr_en),
        .h_addr  (h_wr_addr),
        .h_wdata (h_wr_data),
        .m_len   (m_r),
        .rd_col  (col),
        .operand (operand)
    );

    lstm_mvu_mac #(.DW(DW), .FRAC(FRAC), .ACCW(ACCW)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat   (w_fire),
        .last   (col_last),
        .w      (w_data),
        .op     (operand),
        .result (result)
    );

    lstm_mvu_demux #(.DW(DW), .TW(HAW)) u_demux (
        .valid     (state == ST_EMIT),
        .gate      (gate),
        .data      (result),
        .tag       (lane),
        .out_ready (gate_ready),
        .out_valid (gate_valid),
        .out_data  (gate_data),
        .out_tag   (gate_tag),
        .taken     (out_fire)
    );

endmodule

// File: rtl/lstm_gate_mvu_chk.sv
// Protocol checker for the fused gate unit, bound to every instance of the top.
// Assumes: observes ports only.
module lstm_gate_mvu_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          x_ready,
    input logic          w_ready,
    input logic [2:0]    gate_valid,
    input logic [2:0]    gate_ready,
    input logic [3*DW-1:0] gate_data
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> (!x_ready && !w_ready && gate_valid == 3'b000)); // R1

    AST_STREAMS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_ready && w_ready)); // R2

    AST_NO_WEIGHT_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|gate_valid) |-> !w_ready); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gate_valid & ~gate_ready)) |=> (gate_valid == $past(gate_valid)) && $stable(gate_data)); // R7

    AST_ONE_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_valid)); // R8

    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(|(gate_valid & gate_ready))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9

endmodule

bind lstm_gate_mvu lstm_gate_mvu_chk #(.DW(DW)) u_chk (.*);

// File: tb/lstm_gate_mvu_test.sv
// Bench: behavioural reference of each pass (queue of expected row results),
// compared against the outputs at every falling clock edge.
module lstm_gate_mvu_test;

    localparam int DW = 16;
    localparam int TW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cfg_m = '0;
    logic [3:0]  cfg_n = '0;
    logic        busy, done;
    logic        x_valid = 1'b0;
    logic        x_ready;
    logic [15:0] x_data = '0;
    logic        w_valid = 1'b0;
    logic        w_ready;
    logic [15:0] w_data = '0;
    logic        h_wr_en = 1'b0;
    logic [2:0]  h_wr_addr = '0;
    logic [15:0] h_wr_data = '0;
    logic [2:0]  gate_valid;
    logic [2:0]  gate_ready = '0;
    logic [47:0] gate_data;
    logic [8:0]  gate_tag;

    lstm_gate_mvu uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_m(cfg_m), .cfg_n(cfg_n),
        .busy(busy), .done(done),
        .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
        .h_wr_en(h_wr_en), .h_wr_addr(h_wr_addr), .h_wr_data(h_wr_data),
        .gate_valid(gate_valid), .gate_ready(gate_ready),
        .gate_data(gate_data), .gate_tag(gate_tag)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    g;
        int    t;
        int    d;
        string rq;
    } exp_t;

    exp_t  q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    xs[8];
    int    hs[8];
    int    ws[384];
    int    cur_m, cur_n, xi, wi;
    bit    gaps, rnd_ready, inject, injected;
    bit    exp_done, pass_over, stall_pend;
    logic [2:0]  stall_v;
    logic [47:0] stall_d;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One clock: compare outputs with the model, then drive the next inputs.
    task automatic cycle();
        int g;
        bit rdy;
        exp_t e;
        @(negedge clk);
        if (exp_done) begin
            chk(done === 1'b1, "R9", done, 1);
            chk(busy === 1'b0, "R9", busy, 0);
            exp_done = 0;
            pass_over = 1;
        end else begin
            chk(done === 1'b0, "R9", done, 0);
        end
        chk($countones(gate_valid) <= 1, "R8", gate_valid, 0);
        if (stall_pend) begin
            chk(gate_valid === stall_v, "R7", gate_valid, stall_v);
            chk(gate_data === stall_d, "R7", gate_data, stall_d);
            stall_pend = 0;
        end
        g = -1;
        for (int k = 0; k < 3; k++) if (gate_valid[k]) g = k;
        if (g >= 0) begin
            chk(w_ready === 1'b0, "R7", w_ready, 0);
            if (q.size() == 0) begin
                chk(0, "R4", g, -1);
                gate_ready = 3'b111;
            end else begin
                e = q[0];
                chk(g == e.g, "R4", g, e.g);
                chk(int'(gate_tag[g*TW +: TW]) == e.t, "R4", gate_tag[g*TW +: TW], e.t);
                chk(int'($signed(gate_data[g*DW +: DW])) == e.d, e.rq,
                    $signed(gate_data[g*DW +: DW]), e.d);
                rdy = rnd_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
                gate_ready = rdy ? 3'b111 : 3'b000;
                if (rdy) begin
                    void'(q.pop_front());
                    if (q.size() == 0) exp_done = 1;
                end else begin
                    stall_pend = 1;
                    stall_v = gate_valid;
                    stall_d = gate_data;
                end
            end
        end else begin
            gate_ready = 3'($urandom_range(0, 7));
        end
        if (xi < cur_m) begin
            x_valid = gaps ? ($urandom_range(0, 2) != 0) : 1'b1;
            x_data  = 16'(xs[xi]);
            if (x_valid && x_ready) xi++;
        end else begin
            x_valid = 1'b0;
        end
        if (wi < 3 * cur_n * (cur_m + cur_n)) begin
            w_valid = gaps ? ($urandom_range(0, 2) != 0) : 1'b1;
            w_data  = 16'(ws[wi]);
            if (w_valid && w_ready) wi++;
        end else begin
            w_valid = 1'b0;
        end
        if (inject && !injected && wi == 10) begin
            start = 1'b1;
            cfg_m = 4'd1;
            cfg_n = 4'd1;
            injected = 1;
        end else begin
            start = 1'b0;
        end
    endtask

    // Build the expected results of one pass, then run it to completion.
    task automatic run_pass(input int m, input int n, input bit gp, input bit rr,
                            input bit inj, input string rq);
        longint s;
        int v;
        exp_t e;
        for (int r = 0; r < 3 * n; r++) begin
            s = 0;
            for (int c = 0; c < m + n; c++)
                s += longint'(ws[r * (m + n) + c]) * longint'(c < m ? xs[c] : hs[c - m]);
            s = (s + 2048) >>> 12;
            if (s > 32767) s = 32767;
            if (s < -32768) s = -32768;
            v = int'(s);
            e.g = r / n; e.t = r % n; e.d = v; e.rq = rq;
            q.push_back(e);
        end
        for (int k = 0; k < n; k++) begin
            h_wr_en = 1'b1;
            h_wr_addr = 3'(k);
            h_wr_data = 16'(hs[k]);
            cycle();
        end
        h_wr_en = 1'b0;
        cur_m = m; cur_n = n; xi = 0; wi = 0;
        gaps = gp; rnd_ready = rr; inject = inj; injected = 0;
        pass_over = 0;
        cfg_m = 4'(m);
        cfg_n = 4'(n);
        start = 1'b1;
        cycle();
        chk(busy === 1'b1 && x_ready === 1'b1, "R2", {busy, x_ready}, 3);
        while (!pass_over) cycle();
        cur_m = 0; cur_n = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        cur_m = 0; cur_n = 0; xi = 0; wi = 0;
        exp_done = 0; stall_pend = 0; pass_over = 0;
        gaps = 0; rnd_ready = 0; inject = 0; injected = 0;
        repeat (2) cycle();
        // R1: reset state
        chk(busy === 1'b0, "R1", busy, 0);
        chk(done === 1'b0, "R1", done, 0);
        chk(x_ready === 1'b0 && w_ready === 1'b0, "R1", {x_ready, w_ready}, 0);
        chk(gate_valid === 3'b000, "R1", gate_valid, 0);
        rst_n = 1'b1;
        cycle();

        // R3: small pass with fixed values, full-rate streams
        xs[0] = 4096; xs[1] = -2048; xs[2] = 1024;
        hs[0] = 8192; hs[1] = -4096;
        for (int k = 0; k < 30; k++) ws[k] = (((k * 7) % 11) - 5) * 256;
        run_pass(3, 2, 0, 0, 0, "R3");

        // R11: same x and weights, hidden state rewritten between passes
        hs[0] = -12288; hs[1] = 20000;
        run_pass(3, 2, 0, 0, 0, "R11");

        // R10: largest size, gaps, backpressure and a start pulse while busy
        for (int k = 0; k < 8; k++) begin
            xs[k] = int'($urandom_range(0, 8191)) - 4096;
            hs[k] = int'($urandom_range(0, 8191)) - 4096;
        end
        for (int k = 0; k < 384; k++) ws[k] = int'($urandom_range(0, 16383)) - 8192;
        run_pass(8, 8, 1, 1, 1, "R10");

        // R6: saturation both ways and a half-way rounding case
        xs[0] = 32767; hs[0] = 1;
        ws[0] = 32767;  ws[1] = 32767;
        ws[2] = -32768; ws[3] = -32768;
        ws[4] = 0;      ws[5] = 2048;
        run_pass(1, 1, 0, 1, 0, "R6");

        // R5: uneven shape with random data and stalls
        for (int k = 0; k < 8; k++) begin
            xs[k] = int'($urandom_range(0, 65535)) - 32768;
            hs[k] = int'($urandom_range(0, 65535)) - 32768;
        end
        for (int k = 0; k < 384; k++) ws[k] = int'($urandom_range(0, 8191)) - 4096;
        run_pass(5, 3, 1, 1, 0, "R5");

        // R5: negative half-way rounds toward zero (-0.5 LSB -> 0)
        xs[0] = -1; hs[0] = 0;
        ws[0] = 2048; ws[1] = 0; ws[2] = 6144; ws[3] = 0; ws[4] = -6144; ws[5] = 0;
        run_pass(1, 1, 0, 0, 0, "R5");

        repeat (3) cycle();
        report();
    end

endmodule